// File: doc/BRIEF.md
# Unaligned Byte Write Packer

This block turns a byte-granular write into aligned word writes for a flash word programmer. A command supplies a start byte address, or marks the write as empty. The bytes then arrive on a valid/ready stream whose final byte carries a last flag. The block places each byte in the lane its address selects, little-endian. It issues each completed word to the programmer through a request/done/fail handshake, at the address rounded down to the word boundary.

Lanes that carry no written byte are filled with 0xFF. Programming a flash cell with a 1 leaves it unchanged, so bytes outside the written range keep their contents. A write can therefore start part way into a word, cover any number of full words and end part way into another.

The block keeps a running count of the bytes held in words the programmer has confirmed. When the programmer reports a failure, the operation ends with an error flag at once. No further word is issued, no further byte is taken, and the count still holds the bytes of the words that succeeded. The programmer itself lies outside the block.

Top module: `bytewr_packer`

## Requirements
- R1: The first word of a write whose start address is not a multiple of 4 is issued at the start address with its two low bits cleared. Its lanes below the start offset hold 0xFF. Every word address has its two low bits at zero.
- R2: The first word takes input bytes up to the next word boundary, or up to the byte flagged last if that comes earlier. Its lanes above the last byte taken hold 0xFF.
- R3: Each later word goes to the previous word address plus 4. A word whose four lanes all lie inside the written range carries four input bytes.
- R4: A final word that the stream ends part way through carries the remaining bytes in its lowest lanes, and its higher lanes hold 0xFF.
- R5: Packing is little-endian. The byte at byte address A sits in lane A mod 4, which is data bits [8*(A mod 4)+7 : 8*(A mod 4)].
- R6: A command with cmd_empty=1 issues no word and takes no byte. It raises op_done for one cycle, in the cycle after the command is accepted, with op_err=0 and byte_count=0.
- R7: When the programmer answers pgm_fail, op_done rises in the next cycle with op_err=1. No further word is requested and no further input byte is accepted. byte_count holds the bytes of the words confirmed before the failure.
- R8: byte_count returns to 0 when a command is accepted. It grows by the number of bytes in each word that the programmer confirms with pgm_done. It holds its value after op_done until the next command is accepted.
- R9: pgm_req stays high with stable pgm_addr and pgm_data until pgm_done or pgm_fail. in_ready is low while a word is outstanding and while the block is idle.
- R10: After reset the outputs are cmd_ready=1, in_ready=0, pgm_req=0, op_done=0 and byte_count=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_empty | input | 1 | Write carries no bytes |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Final byte of the write |
| pgm_req | output | 1 | Word program request |
| pgm_addr | output | ADDR_W | Word-aligned byte address |
| pgm_data | output | 8*LANES | Word to program, lane 0 in the low byte |
| pgm_done | input | 1 | Word programmed successfully |
| pgm_fail | input | 1 | Word program failed |
| op_done | output | 1 | One-cycle end-of-operation pulse |
| op_err | output | 1 | Operation ended by a failure, valid with op_done |
| byte_count | output | CNT_W | Bytes in confirmed words |

## Verification
The assertions assume that the programmer raises pgm_done or pgm_fail only while pgm_req is high, for a single cycle per request. They also assume that cmd_empty is meaningful only together with cmd_valid, and that the stream marks exactly one last byte per non-empty write. The bench programmer model answers each request once, after a delay that varies from word to word, and clears its answer in the following cycle. The byte feeder sets in_last only on the final byte of the write it was told to send, and withdraws the stream as soon as the operation ends.

// File: rtl/bwp_pkg.sv
package bwp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PROG = 2'd2
  } bwp_state_e;

  localparam logic [7:0] PAD_BYTE = 8'hFF;
endpackage

// File: rtl/bwp_lane_buffer.sv
module bwp_lane_buffer #(
  parameter int LANES = 4,
  localparam int OFS_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int FILL_W = OFS_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic [OFS_W-1:0]     start_lane,
  input  logic                 wr_en,
  input  logic [7:0]           wr_byte,
  output logic [8*LANES-1:0]   word,
  output logic [OFS_W-1:0]     lane,
  output logic [FILL_W-1:0]    fill_n,
  output logic                 lane_top
);
  import bwp_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lane_q <= PAD_BYTE;
      else if (clear)
        lane_q <= PAD_BYTE;
      else if (wr_en && lane == OFS_W'(g))
        lane_q <= wr_byte;
    end
    assign word[8*g +: 8] = lane_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane   <= '0;
      fill_n <= '0;
    end else if (clear) begin
      lane   <= start_lane;
      fill_n <= '0;
    end else if (wr_en) begin
      lane   <= lane + 1'b1;
      fill_n <= fill_n + 1'b1;
    end
  end

  assign lane_top = (lane == OFS_W'(LANES - 1));
endmodule

// File: rtl/bwp_byte_tally.sv
module bwp_byte_tally #(
  parameter int CNT_W = 16,
  parameter int ADD_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             add_en,
  input  logic [ADD_W-1:0] add_n,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (clear)
      count <= '0;
    else if (add_en)
      count <= count + CNT_W'(add_n);
  end
endmodule

// File: rtl/bytewr_packer.sv
module bytewr_packer #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int LANES  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic                cmd_empty,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [7:0]          in_data,
  input  logic                in_last,
  output logic                pgm_req,
  output logic [ADDR_W-1:0]   pgm_addr,
  output logic [8*LANES-1:0]  pgm_data,
  input  logic                pgm_done,
  input  logic                pgm_fail,
  output logic                op_done,
  output logic                op_err,
  output logic [CNT_W-1:0]    byte_count
);
  import bwp_pkg::*;

  localparam int OFS_W  = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int FILL_W = OFS_W + 1;
  localparam logic [ADDR_W-1:0] LANE_MASK = ADDR_W'(LANES - 1);

  function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a);
    return a & ~LANE_MASK;
  endfunction

  function automatic logic [OFS_W-1:0] lane_of(input logic [ADDR_W-1:0] a);
    return OFS_W'(a & LANE_MASK);
  endfunction

  function automatic logic [ADDR_W-1:0] next_word(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(LANES);
  endfunction

  bwp_state_e        state;
  logic [ADDR_W-1:0] word_addr;
  logic              last_seen;

  // named events
  logic              cmd_take;
  logic              byte_take;
  logic              word_close;
  logic              word_ok;
  logic              word_bad;
  logic              op_end;
  logic              buf_clear;
  logic [OFS_W-1:0]  buf_start;

  logic [OFS_W-1:0]  cur_lane;
  logic [FILL_W-1:0] fill_n;
  logic              lane_top;

  assign cmd_ready  = (state == ST_IDLE);
  assign in_ready   = (state == ST_FILL);
  assign pgm_req    = (state == ST_PROG);
  assign pgm_addr   = word_addr;

  assign cmd_take   = cmd_ready && cmd_valid;
  assign byte_take  = in_ready && in_valid;
  assign word_close = byte_take && (in_last || lane_top);
  assign word_bad   = pgm_req && pgm_fail;
  assign word_ok    = pgm_req && pgm_done && !pgm_fail;
  assign op_end     = (cmd_take && cmd_empty) || word_bad || (word_ok && last_seen);
  assign buf_clear  = (cmd_take && !cmd_empty) || (word_ok && !last_seen);
  assign buf_start  = cmd_take ? lane_of(cmd_addr) : '0;

  bwp_lane_buffer #(.LANES(LANES)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (buf_clear),
    .start_lane (buf_start),
    .wr_en      (byte_take),
    .wr_byte    (in_data),
    .word       (pgm_data),
    .lane       (cur_lane),
    .fill_n     (fill_n),
    .lane_top   (lane_top)
  );

  bwp_byte_tally #(.CNT_W(CNT_W), .ADD_W(FILL_W)) u_tally (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (cmd_take),
    .add_en (word_ok),
    .add_n  (fill_n),
    .count  (byte_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      word_addr <= '0;
      last_seen <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_take) begin
          word_addr <= align_down(cmd_addr);
          last_seen <= 1'b0;
          if (!cmd_empty) state <= ST_FILL;
        end
        ST_FILL: if (word_close) begin
          last_seen <= in_last;
          state     <= ST_PROG;
        end
        ST_PROG: begin
          if (word_bad || (word_ok && last_seen))
            state <= ST_IDLE;
          else if (word_ok) begin
            word_addr <= next_word(word_addr);
            state     <= ST_FILL;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_done <= 1'b0;
      op_err  <= 1'b0;
    end else begin
      op_done <= op_end;
      if (op_end) op_err <= word_bad;
    end
  end
endmodule

// File: rtl/bwp_checker.sv
module bwp_checker #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int LANES  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_take,
  input logic                cmd_empty,
  input logic                in_ready,
  input logic                pgm_req,
  input logic [ADDR_W-1:0]   pgm_addr,
  input logic [8*LANES-1:0]  pgm_data,
  input logic                pgm_done,
  input logic                pgm_fail,
  input logic                word_ok,
  input logic                word_bad,
  input logic                op_done,
  input logic                op_err,
  input logic [CNT_W-1:0]    byte_count
);
  localparam logic [ADDR_W-1:0] MASK = ADDR_W'(LANES - 1);

  a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |-> ((pgm_addr & MASK) == '0));

  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_req && !pgm_done && !pgm_fail) |=> (pgm_req && $stable(pgm_addr) && $stable(pgm_data)));

  a_r9_no_byte_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |-> !in_ready);

  a_r6_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_take && cmd_empty) |=> (op_done && !op_err && byte_count == '0 && !pgm_req && !in_ready));

  a_r7_fail_abort: assert property (@(posedge clk) disable iff (!rst_n)
    word_bad |=> (op_done && op_err && $stable(byte_count) && !pgm_req && !in_ready));

  a_r3_next_addr: assert property (@(posedge clk) disable iff (!rst_n)
    word_ok |=> (op_done || pgm_addr == $past(pgm_addr) + ADDR_W'(LANES)));

  a_r8_count_grows: assert property (@(posedge clk) disable iff (!rst_n)
    word_ok |=> (byte_count > $past(byte_count)));

  a_r8_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take |=> (byte_count == '0));
endmodule

bind bytewr_packer bwp_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_take   (cmd_take),
  .cmd_empty  (cmd_empty),
  .in_ready   (in_ready),
  .pgm_req    (pgm_req),
  .pgm_addr   (pgm_addr),
  .pgm_data   (pgm_data),
  .pgm_done   (pgm_done),
  .pgm_fail   (pgm_fail),
  .word_ok    (word_ok),
  .word_bad   (word_bad),
  .op_done    (op_done),
  .op_err     (op_err),
  .byte_count (byte_count)
);

// File: tb/bytewr_packer_bench.sv
module bytewr_packer_bench;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;
  localparam int LANES  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic cmd_empty = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic in_last = 1'b0;
  logic pgm_req;
  logic [ADDR_W-1:0] pgm_addr;
  logic [8*LANES-1:0] pgm_data;
  logic pgm_done = 1'b0;
  logic pgm_fail = 1'b0;
  logic op_done;
  logic op_err;
  logic [CNT_W-1:0] byte_count;

  always #5 clk = ~clk;

  bytewr_packer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LANES(LANES)) u_bytewr_packer (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_empty(cmd_empty),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .pgm_req(pgm_req), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .pgm_done(pgm_done), .pgm_fail(pgm_fail),
    .op_done(op_done), .op_err(op_err), .byte_count(byte_count)
  );

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  // programmer model state
  int rec_n = 0;
  int fail_at = -1;
  int resp_delay = 0;
  int wcnt = 0;
  logic [ADDR_W-1:0]  rec_addr [0:15];
  logic [8*LANES-1:0] rec_data [0:15];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (pgm_done || pgm_fail) begin
      pgm_done = 1'b0;
      pgm_fail = 1'b0;
      wcnt = 0;
    end else if (pgm_req) begin
      if (wcnt >= resp_delay) begin
        if (rec_n < 16) begin
          rec_addr[rec_n] = pgm_addr;
          rec_data[rec_n] = pgm_data;
        end
        if (rec_n == fail_at) pgm_fail = 1'b1;
        else pgm_done = 1'b1;
        rec_n++;
      end else begin
        wcnt++;
      end
    end
  end

  function automatic logic [7:0] pat(input int base, input int i);
    return 8'((base * 3 + i * 29 + 17) & 255);
  endfunction

  function automatic int cum(input int off, input int len, input int w);
    int v = LANES * (w + 1) - off;
    return (v < len) ? v : len;
  endfunction

  int opn = 0;

  task automatic run_op(input int off, input int len, input int gap, input int fa);
    int base, nwords, taken, cyc, expw, expcnt;
    bit done, err, expect_err;
    logic [CNT_W-1:0] cnt;
    base = 16'h0200 + 16 * opn + off;
    opn++;
    rec_n = 0;
    fail_at = fa;
    resp_delay = opn % 3;
    nwords = (len == 0) ? 0 : (off + len + LANES - 1) / LANES;
    expect_err = (fa >= 0) && (fa < nwords);

    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_addr  = ADDR_W'(base);
    cmd_empty = (len == 0);
    #1;
    if (!cmd_ready) check(0, "R10", "cmd_ready idle before command", 0, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_empty = 1'b0;

    taken = 0; done = 0; err = 0; cyc = 0; cnt = '0;
    while (!done && cyc < 400) begin
      in_valid = (taken < len) && !(gap != 0 && (cyc % 3) == 2);
      in_data  = pat(base, taken);
      in_last  = (taken == len - 1);
      #1;
      if (op_done) begin
        done = 1; err = op_err; cnt = byte_count;
      end else if (in_valid && in_ready) begin
        taken++;
      end
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    check(done, "R8", "operation completes", done, 1);

    if (len == 0) begin
      check(cyc == 1, "R6", "empty write done timing (cycles)", cyc, 1);
      check(rec_n == 0, "R6", "empty write word count", rec_n, 0);
      check(err == 0 && cnt == 0, "R6", "empty write err/count", {err, cnt}, 0);
      return;
    end

    expw = expect_err ? fa + 1 : nwords;
    expcnt = expect_err ? ((fa == 0) ? 0 : cum(off, len, fa - 1)) : len;
    check(rec_n == expw, expect_err ? "R7" : "R3", "words issued", rec_n, expw);
    check(err == expect_err, "R7", "op_err", err, expect_err);
    check(cnt == CNT_W'(expcnt), expect_err ? "R7" : "R8", "byte_count", cnt, expcnt);
    if (expect_err)
      check(taken == cum(off, len, fa), "R7", "bytes consumed before abort", taken, cum(off, len, fa));
    for (int w = 0; w < rec_n && w < 16; w++) begin
      logic [8*LANES-1:0] ed;
      int ea;
      ea = (base & ~(LANES - 1)) + LANES * w;
      for (int l = 0; l < LANES; l++) begin
        int idx = w * LANES + l - off;
        ed[8*l +: 8] = (idx >= 0 && idx < len) ? pat(base, idx) : 8'hFF;
      end
      check(rec_addr[w] == ADDR_W'(ea), (w == 0) ? "R1" : "R3", "word address", rec_addr[w], ea);
      check(rec_data[w] == ed, (w == 0) ? "R2" : ((w == nwords - 1) ? "R4" : "R5"),
            "word data", rec_data[w], ed);
    end
    @(negedge clk);
    @(negedge clk);
    #1;
    check(byte_count == CNT_W'(expcnt), "R8", "count held after done", byte_count, expcnt);
    check(in_ready == 0 && pgm_req == 0, "R9", "idle after done: in_ready/pgm_req",
          {in_ready, pgm_req}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(cmd_ready == 1, "R10", "reset cmd_ready", cmd_ready, 1);
    check(in_ready == 0 && pgm_req == 0, "R10", "reset in_ready/pgm_req", {in_ready, pgm_req}, 0);
    check(op_done == 0 && byte_count == 0, "R10", "reset op_done/byte_count", {op_done, byte_count}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep: offset x length x stream gaps, no failures (R1..R6, R8)
    for (int gap = 0; gap < 2; gap++)
      for (int off = 0; off < LANES; off++)
        for (int len = 0; len <= 10; len++)
          run_op(off, len, gap, -1);

    // failure on each word position (R7), then a clean write (R8 clear)
    for (int off = 0; off < LANES; off++) begin
      for (int fa = 0; fa < (off + 9 + LANES - 1) / LANES; fa++) begin
        run_op(off, 9, fa % 2, fa);
        run_op(off, 3, 0, -1);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule